// File: doc/BRIEF.md
# USB Host Pipe Transfer Controller

This block sequences a single host-side USB pipe that serves either as a control pipe or as a plain OUT pipe. Firmware selects the token for each transaction through a register-style write; on a control pipe that write also forces the starting data toggle for the stage being entered. The block follows the stage of a control transfer (SETUP, optional data, status) from the order of those token writes.

Bank ownership with the CPU-side FIFO is a two-flag handshake. A bank-owner flag, set by hardware and cleared only by software, hands the bank to the controller when the CPU clears it. When a transaction on that bank is acknowledged, the flag returns the bank to the CPU and a sent flag is raised, which can drive an interrupt. A pending bank keeps frame generation running even when firmware has asked for suspend. Serial encoding, CRC, framing and the physical layer are handled elsewhere; transaction results arrive as abstract handshake events.

Top module: `usb_pipe_xfer_ctrl`

## Requirements
- R1: A synchronous active-high reset sets `token` to SETUP (00), `toggle` to 0, `stage` to SETUP (00), `bank_cpu` to 1, and clears `sent_flag`, `irq` and any held bank release.
- R2: A `tok_wr` strobe loads `tok_sel` into `token` at the next edge. Token codes: 00 SETUP, 01 IN, 10 OUT.
- R3: On a control pipe (`is_ctrl`=1), a `tok_wr` sets `toggle` to 0 for SETUP and to 1 for IN or OUT at the next edge. When `is_ctrl`=0, `tok_wr` leaves `toggle` unchanged.
- R4: `stage` (00 SETUP, 01 DATA, 10 STATUS) tracks control token writes. A SETUP write moves it to SETUP. An IN/OUT write while in SETUP moves it to DATA and records the direction. An IN/OUT write in DATA opposite to the recorded direction moves it to STATUS.
- R5: `tx_req` is 1 only when `cfg_ok`=1, `freeze`=0 and `bank_cpu`=0. A handshake event (`hs_valid`) while `tx_req`=0 changes nothing.
- R6: An acknowledged handshake (`hs_valid`=1, `hs_ack`=1) while `tx_req`=1 sets `sent_flag` and `bank_cpu` and flips `toggle`, all at the next edge.
- R7: A handshake with `hs_ack`=0 (NAK or timeout) leaves `toggle`, `bank_cpu` and `sent_flag` unchanged.
- R8: `irq` equals `sent_flag` AND `sent_ie`.
- R9: A `sent_clr` strobe clears `sent_flag`. If an acknowledged handshake sets it in the same cycle, the set wins.
- R10: A `bank_rel` strobe clears `bank_cpu` at the next edge when `freeze`=0. A release made while frozen is held and takes effect at the first edge after `freeze` falls.
- R11: `sof_active` is 1 when `sof_en`=1, or when a bank is ready to send (`tx_req`=1) even though `sof_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| is_ctrl | input | 1 | Pipe acts as a control pipe |
| cfg_ok | input | 1 | Pipe is configured |
| freeze | input | 1 | Pipe frozen; no transactions |
| tok_wr | input | 1 | Token write strobe |
| tok_sel | input | 2 | Token to write (00 SETUP, 01 IN, 10 OUT) |
| bank_rel | input | 1 | CPU releases the bank to the controller |
| sent_clr | input | 1 | Software clear of the sent flag |
| sent_ie | input | 1 | Interrupt enable for the sent flag |
| sof_en | input | 1 | Frame generation enable (0 requests suspend) |
| hs_valid | input | 1 | A transaction result is present |
| hs_ack | input | 1 | Result was ACK (1) or NAK/timeout (0) |
| token | output | 2 | Token for the next transaction |
| toggle | output | 1 | Data toggle for the next transaction |
| stage | output | 2 | Control stage (00 SETUP, 01 DATA, 10 STATUS) |
| tx_req | output | 1 | Bank ready and pipe allowed to send |
| bank_cpu | output | 1 | Bank owned by the CPU |
| sent_flag | output | 1 | Bank has been sent and freed |
| irq | output | 1 | Interrupt request |
| sof_active | output | 1 | Frame generation running |

## Verification
Two pairs of events can land on the same edge. The first is an acknowledged handshake arriving together with a software clear of the sent flag. The bench drives both in one cycle and expects the flag still set afterwards. The second is a bank release made while the pipe is frozen. The bench checks that the bank stays with the CPU across the frozen cycles and passes to the controller exactly one edge after the freeze falls.

// File: rtl/usb_pipe_xfer_ctrl.sv
module usb_pipe_xfer_ctrl (
  input  logic       clk,
  input  logic       rst,
  input  logic       is_ctrl,
  input  logic       cfg_ok,
  input  logic       freeze,
  input  logic       tok_wr,
  input  logic [1:0] tok_sel,
  input  logic       bank_rel,
  input  logic       sent_clr,
  input  logic       sent_ie,
  input  logic       sof_en,
  input  logic       hs_valid,
  input  logic       hs_ack,
  output logic [1:0] token,
  output logic       toggle,
  output logic [1:0] stage,
  output logic       tx_req,
  output logic       bank_cpu,
  output logic       sent_flag,
  output logic       irq,
  output logic       sof_active
);
  localparam logic [1:0] TK_SETUP = 2'b00;
  localparam logic [1:0] TK_IN    = 2'b01;
  localparam logic [1:0] ST_SETUP = 2'b00;
  localparam logic [1:0] ST_DATA  = 2'b01;
  localparam logic [1:0] ST_STAT  = 2'b10;

  logic rel_held, data_in, acked;

  assign tx_req     = cfg_ok & ~freeze & ~bank_cpu;
  assign acked      = hs_valid & hs_ack & tx_req;
  assign irq        = sent_flag & sent_ie;
  assign sof_active = sof_en | tx_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      token     <= TK_SETUP;
      toggle    <= 1'b0;
      stage     <= ST_SETUP;
      data_in   <= 1'b0;
      bank_cpu  <= 1'b1;
      sent_flag <= 1'b0;
      rel_held  <= 1'b0;
    end else begin
      if (tok_wr) begin
        token <= tok_sel;
        if (is_ctrl) begin
          toggle <= (tok_sel != TK_SETUP);
          if (tok_sel == TK_SETUP) stage <= ST_SETUP;
          else if (stage == ST_SETUP) begin
            stage   <= ST_DATA;
            data_in <= (tok_sel == TK_IN);
          end else if (stage == ST_DATA && data_in != (tok_sel == TK_IN))
            stage <= ST_STAT;
        end
      end else if (acked) toggle <= ~toggle;

      if (acked) bank_cpu <= 1'b1;
      else if ((bank_rel | rel_held) & ~freeze) bank_cpu <= 1'b0;

      if (freeze & bank_rel) rel_held <= 1'b1;
      else if (~freeze) rel_held <= 1'b0;

      if (acked) sent_flag <= 1'b1;
      else if (sent_clr) sent_flag <= 1'b0;
    end
  end

  assert_setup_tog_R3: assert property (@(posedge clk) disable iff (rst)
    (is_ctrl && tok_wr) |=> (toggle == ($past(tok_sel) != TK_SETUP)));
  assert_gate_R5: assert property (@(posedge clk) disable iff (rst)
    (hs_valid && (freeze || !cfg_ok) && !tok_wr && !bank_rel) |=> ($stable(toggle) && $stable(sent_flag) || $past(sent_clr)));
  assert_ack_R6: assert property (@(posedge clk) disable iff (rst)
    (hs_valid && hs_ack && cfg_ok && !freeze && !bank_cpu) |=> (bank_cpu && sent_flag));
  assert_nak_R7: assert property (@(posedge clk) disable iff (rst)
    (hs_valid && !hs_ack && !tok_wr && !sent_clr) |=> ($stable(toggle) && $stable(sent_flag)));
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (acked && sent_clr) |=> sent_flag);
  assert_frozen_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (freeze && bank_cpu) |=> bank_cpu);
endmodule

// File: tb/usb_pipe_xfer_ctrl_tb.sv
module usb_pipe_xfer_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  logic clk = 1'b0, rst = 1'b1;
  logic is_ctrl = 1'b1, cfg_ok = 1'b1, freeze = 1'b0, tok_wr = 1'b0;
  logic [1:0] tok_sel = 2'b00;
  logic bank_rel = 1'b0, sent_clr = 1'b0, sent_ie = 1'b0, sof_en = 1'b1;
  logic hs_valid = 1'b0, hs_ack = 1'b0;
  logic [1:0] token, stage;
  logic toggle, tx_req, bank_cpu, sent_flag, irq, sof_active;
  int checks = 0, failures = 0;

  usb_pipe_xfer_ctrl u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
    tok_wr = 0; bank_rel = 0; sent_clr = 0; hs_valid = 0; hs_ack = 0;
  endtask

  task automatic wr_tok(input logic [1:0] t);
    tok_wr = 1; tok_sel = t; tick();
  endtask

  task automatic ack(input logic a);
    hs_valid = 1; hs_ack = a; tick();
  endtask

  task automatic t_reset;
    chk("R1 token", token, 0); chk("R1 toggle", toggle, 0);
    chk("R1 stage", stage, 0); chk("R1 bank_cpu", bank_cpu, 1);
    chk("R1 sent", sent_flag, 0); chk("R1 irq", irq, 0);
  endtask

  task automatic t_control;
    wr_tok(2'b00);
    chk("R2 token", token, 0); chk("R3 setup toggle", toggle, 0);
    bank_rel = 1; tick();
    chk("R10 release", bank_cpu, 0); chk("R5 tx_req", tx_req, 1);
    sent_ie = 1; ack(1);
    chk("R6 bank back", bank_cpu, 1); chk("R6 sent", sent_flag, 1);
    chk("R6 flip", toggle, 1); chk("R8 irq", irq, 1);
    sent_ie = 0; #1 chk("R8 irq masked", irq, 0);
    sent_clr = 1; tick(); chk("R9 clear", sent_flag, 0);
    wr_tok(2'b01);
    chk("R2 token IN", token, 1); chk("R3 IN toggle", toggle, 1); chk("R4 data", stage, 1);
    wr_tok(2'b01); chk("R4 same dir", stage, 1);
    wr_tok(2'b10);
    chk("R3 OUT toggle", toggle, 1); chk("R4 status", stage, 2);
    wr_tok(2'b00); chk("R4 back setup", stage, 0); chk("R3 setup again", toggle, 0);
  endtask

  task automatic t_nak;
    bank_rel = 1; tick();
    ack(0);
    chk("R7 toggle", toggle, 0); chk("R7 bank", bank_cpu, 0); chk("R7 sent", sent_flag, 0);
    ack(1); chk("R6 flip1", toggle, 1);
    bank_rel = 1; tick(); ack(1); chk("R6 flip2", toggle, 0);
    sent_clr = 1; tick();
  endtask

  task automatic t_gate;
    bank_rel = 1; tick();
    freeze = 1; #1 chk("R5 frozen tx_req", tx_req, 0);
    ack(1);
    chk("R5 frozen ack ignored bank", bank_cpu, 0); chk("R5 frozen sent", sent_flag, 0);
    chk("R5 frozen toggle", toggle, 0);
    freeze = 0; cfg_ok = 0; #1 chk("R5 unconfigured", tx_req, 0);
    ack(1); chk("R5 unconfig ignored", sent_flag, 0);
    cfg_ok = 1;
    ack(1);
    freeze = 1; bank_rel = 1; tick();
    chk("R10 held frozen", bank_cpu, 1); tick(); chk("R10 still held", bank_cpu, 1);
    freeze = 0; #1 chk("R10 not yet", bank_cpu, 1);
    tick(); chk("R10 after unfreeze", bank_cpu, 0);
  endtask

  task automatic t_same_cycle;
    sent_clr = 1; tick();
    hs_valid = 1; hs_ack = 1; sent_clr = 1; tick();
    chk("R9 set wins", sent_flag, 1);
  endtask

  task automatic t_nonctrl;
    is_ctrl = 0;
    chk("R3 pre toggle", toggle, 0);
    bank_rel = 1; tick(); ack(1);
    wr_tok(2'b00);
    chk("R3 nonctrl toggle kept", toggle, 1); chk("R2 nonctrl token", token, 0);
    is_ctrl = 1;
  endtask

  task automatic t_suspend;
    sof_en = 0; #1 chk("R11 idle suspend", sof_active, 0);
    bank_rel = 1; tick();
    chk("R11 pending overrides", sof_active, 1);
    ack(1); chk("R11 after send", sof_active, 0);
    sof_en = 1; #1 chk("R11 enabled", sof_active, 1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset(); t_control(); t_nak(); t_gate();
        t_same_cycle(); t_nonctrl(); t_suspend();
      end
      begin
        repeat (5000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=0 expected=1");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule